// File: doc/BRIEF.md
# Sticky RAM Access Lock Filter

This block stands between a host register port and a battery-backed byte RAM. The RAM holds a number of lower banks of 128 bytes each and one separate upper block of 128 bytes. Each host access names a region (one lower bank or the upper block), a 7-bit byte address and a direction. The filter checks the access against a lock register. It then either passes the access on to the RAM port, or it blocks it. A blocked write is dropped. A blocked read is answered with FFh and never reaches the RAM.

The lock register has five active bits, positions 7 to 3. Each bit guards its own address window, and the windows overlap. Software can set these bits but cannot clear them. Only the hardware reset input returns them to 0. Positions 2 to 0 are reserved.

The host request, the RAM request and the read response are valid/ready channels. The block takes one transaction at a time. `h_ready` is high only while nothing is in flight. A request on the RAM port keeps its fields steady until `m_ready` accepts it. A read response keeps `r_data` steady until `r_ready` takes it. The RAM returns read data on `m_rvalid` and cannot be stalled. The lock register port is plain control with no handshake.

Top module: `ram_guard_top`

## Requirements
- R1: After hardware reset (`rst_n` low), the lock register reads 00h.
- R2: A lock write ORs bits 7..3 of `lk_wdata` into the lock register. A bit that is 1 stays 1 until hardware reset, so writing 0 does not clear it.
- R3: Lock bits 2..0 are reserved. They always read 0, and writing 1 to them changes nothing.
- R4: With lock bit 3 set, every access to the upper block is blocked, both reads and writes.
- R5: With lock bit 4 set, reads of upper-block bytes 00h-1Fh are blocked. A blocked read returns FFh on `r_data`.
- R6: With lock bit 5 set, writes to upper-block bytes 00h-1Fh are blocked.
- R7: With lock bit 6 set, these writes are blocked: bytes 0Eh-3Fh of every lower bank, bytes 40h-7Fh of lower bank 0, and every byte of the upper block.
- R8: With lock bit 7 set, reads and writes to bytes 38h-3Fh of every lower bank are blocked.
- R9: An access is blocked when at least one set lock bit covers it. An access that no set bit covers is allowed.
- R10: An allowed access appears on the RAM port exactly once, with the host's region, address, direction and write data unchanged. For an allowed read, `r_data` carries the RAM's read data.
- R11: Handshakes. `h_ready` is high only while idle. `m_valid` and its fields stay stable until `m_ready` is seen. `r_valid` and `r_data` stay stable until `r_ready` is seen.
- R12: A blocked access never raises `m_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset; the only way to clear lock bits |
| lk_wr | input | 1 | Lock register write strobe |
| lk_wdata | input | 8 | Lock register write data |
| lk_rdata | output | 8 | Current lock register value |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Host request ready |
| h_write | input | 1 | 1 = write, 0 = read |
| h_upper | input | 1 | 1 selects the upper block (`h_bank` is then ignored) |
| h_bank | input | BANK_W | Lower bank number |
| h_addr | input | 7 | Byte address within the region |
| h_wdata | input | 8 | Write data |
| m_valid | output | 1 | RAM request valid |
| m_ready | input | 1 | RAM request ready |
| m_write | output | 1 | RAM request direction |
| m_upper | output | 1 | RAM request selects the upper block |
| m_bank | output | BANK_W | RAM request lower bank |
| m_addr | output | 7 | RAM request byte address |
| m_wdata | output | 8 | RAM write data |
| m_rvalid | input | 1 | RAM read data valid (at least one cycle after the request handshake) |
| m_rdata | input | 8 | RAM read data |
| r_valid | output | 1 | Read response valid |
| r_ready | input | 1 | Read response ready |
| r_data | output | 8 | Read response data (FFh for a blocked read) |

## Verification
Some properties are checked on every cycle. They are: lock bits never fall outside reset, the RAM request and the read response hold under back-pressure, `h_ready` is high only when no channel is busy, a blocked access never drives `m_valid`, a blocked read answers FFh, and the upper block is shut whenever bit 3 is set. Other behaviour can only be shown by the bench scenarios. That includes the exact edges of each window, the way overlapping bits combine, the drop of a blocked write (seen later as an unchanged read-back), and the fact that only a hardware reset clears a bit. To show these, the bench sweeps every byte of every region under a range of lock settings, with a reset between settings.

// File: rtl/ram_guard_pkg.sv
package ram_guard_pkg;
  localparam int LOCK_W   = 8;
  localparam int LOCK_LO  = 3;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 8;
  localparam logic [DATA_W-1:0] FILL = '1;

  // lock bit positions
  localparam int B_UP_SHUT  = 3;
  localparam int B_UP_RHIDE = 4;
  localparam int B_UP_WHIDE = 5;
  localparam int B_WR_FRZ   = 6;
  localparam int B_SECRET   = 7;

  // address windows
  localparam logic [ADDR_W-1:0] UP_LOW_END  = 7'h1F;
  localparam logic [ADDR_W-1:0] FRZ_LO      = 7'h0E;
  localparam logic [ADDR_W-1:0] FRZ_HI      = 7'h3F;
  localparam logic [ADDR_W-1:0] BANK0_HI_LO = 7'h40;
  localparam logic [ADDR_W-1:0] SEC_LO      = 7'h38;
  localparam logic [ADDR_W-1:0] SEC_HI      = 7'h3F;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } guard_state_e;

  // does the rule owned by lock bit idx cover this access?
  function automatic logic rule_covers(input int idx, input logic wr,
                                       input logic up, input logic bank0,
                                       input logic [ADDR_W-1:0] a);
    logic hit;
    hit = 1'b0;
    case (idx)
      B_UP_SHUT:  hit = up;
      B_UP_RHIDE: hit = up && !wr && (a <= UP_LOW_END);
      B_UP_WHIDE: hit = up && wr && (a <= UP_LOW_END);
      B_WR_FRZ:   hit = wr && (up ||
                               ((a >= FRZ_LO) && (a <= FRZ_HI)) ||
                               (bank0 && (a >= BANK0_HI_LO)));
      B_SECRET:   hit = !up && (a >= SEC_LO) && (a <= SEC_HI);
      default:    hit = 1'b0;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/ram_guard_lock.sv
module ram_guard_lock
  import ram_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LOCK_W-1:0] wdata,
  output logic [LOCK_W-1:0] lock
);
  localparam int ACT_W = LOCK_W - LOCK_LO;

  logic [ACT_W-1:0] act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     act_q <= '0;
    else if (wr_en) act_q <= act_q | wdata[LOCK_W-1:LOCK_LO];
  end

  assign lock = {act_q, {LOCK_LO{1'b0}}};

  // R2
  sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock & $past(lock)) == $past(lock)));
endmodule

// File: rtl/ram_guard_decode.sv
module ram_guard_decode
  import ram_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOCK_W-1:0] lock,
  input  logic              wr,
  input  logic              up,
  input  logic              bank0,
  input  logic [ADDR_W-1:0] addr,
  output logic              blocked
);
  logic [LOCK_W-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < LOCK_W; gi++) begin : g_rule
      if (gi < LOCK_LO) begin : g_rsvd
        assign hit[gi] = 1'b0;
      end else begin : g_act
        assign hit[gi] = lock[gi] && rule_covers(gi, wr, up, bank0, addr);
      end
    end
  endgenerate

  // any covering bit blocks
  assign blocked = |hit;

  // R4
  upper_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && lock[B_UP_SHUT]) |-> blocked);
endmodule

// File: rtl/ram_guard_path.sv
module ram_guard_path
  import ram_guard_pkg::*;
#(
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_in,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_write,
  input  logic              h_upper,
  input  logic [BANK_W-1:0] h_bank,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_write,
  output logic              m_upper,
  output logic [BANK_W-1:0] m_bank,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_wdata,
  input  logic              m_rvalid,
  input  logic [DATA_W-1:0] m_rdata,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [DATA_W-1:0] r_data
);
  guard_state_e      st_q;
  logic              wr_q, up_q, blk_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wr_q   <= 1'b0;
      up_q   <= 1'b0;
      blk_q  <= 1'b0;
      bank_q <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (h_valid) begin
          wr_q   <= h_write;
          up_q   <= h_upper;
          bank_q <= h_bank;
          addr_q <= h_addr;
          wd_q   <= h_wdata;
          blk_q  <= blk_in;
          rd_q   <= FILL;
          if (blk_in) st_q <= h_write ? ST_IDLE : ST_RESP;
          else        st_q <= ST_ISSUE;
        end
        ST_ISSUE: if (m_ready) st_q <= wr_q ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (m_rvalid) begin
          rd_q <= m_rdata;
          st_q <= ST_RESP;
        end
        ST_RESP: if (r_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign h_ready = (st_q == ST_IDLE);
  assign m_valid = (st_q == ST_ISSUE);
  assign r_valid = (st_q == ST_RESP);
  assign m_write = wr_q;
  assign m_upper = up_q;
  assign m_bank  = bank_q;
  assign m_addr  = addr_q;
  assign m_wdata = wd_q;
  assign r_data  = rd_q;

  // R11
  mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable({m_write, m_upper, m_bank, m_addr, m_wdata})));
  // R11
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data)));
  // R11
  idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_ready |-> (!m_valid && !r_valid));
  // R12
  no_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !blk_q);
  // R5
  fill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && blk_q) |-> (r_data == FILL));
endmodule

// File: rtl/ram_guard_top.sv
module ram_guard_top
  import ram_guard_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_wr,
  input  logic [7:0]        lk_wdata,
  output logic [7:0]        lk_rdata,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_write,
  input  logic              h_upper,
  input  logic [BANK_W-1:0] h_bank,
  input  logic [6:0]        h_addr,
  input  logic [7:0]        h_wdata,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_write,
  output logic              m_upper,
  output logic [BANK_W-1:0] m_bank,
  output logic [6:0]        m_addr,
  output logic [7:0]        m_wdata,
  input  logic              m_rvalid,
  input  logic [7:0]        m_rdata,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [7:0]        r_data
);
  logic [LOCK_W-1:0] lock;
  logic              blocked;

  ram_guard_lock u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (lk_wr),
    .wdata (lk_wdata),
    .lock  (lock)
  );

  ram_guard_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock    (lock),
    .wr      (h_write),
    .up      (h_upper),
    .bank0   (h_bank == '0),
    .addr    (h_addr),
    .blocked (blocked)
  );

  ram_guard_path #(.BANK_W(BANK_W)) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .blk_in   (blocked),
    .h_valid  (h_valid),
    .h_ready  (h_ready),
    .h_write  (h_write),
    .h_upper  (h_upper),
    .h_bank   (h_bank),
    .h_addr   (h_addr),
    .h_wdata  (h_wdata),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_write  (m_write),
    .m_upper  (m_upper),
    .m_bank   (m_bank),
    .m_addr   (m_addr),
    .m_wdata  (m_wdata),
    .m_rvalid (m_rvalid),
    .m_rdata  (m_rdata),
    .r_valid  (r_valid),
    .r_ready  (r_ready),
    .r_data   (r_data)
  );

  assign lk_rdata = lock;
endmodule

// File: tb/tb_ram_guard_top.sv
module tb_ram_guard_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2;
  localparam int BW = 1;
  localparam int DEPTH = (NB + 1) * 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_wr = 1'b0;
  logic [7:0] lk_wdata = '0, lk_rdata;
  logic h_valid = 1'b0, h_ready, h_write = 1'b0, h_upper = 1'b0;
  logic [BW-1:0] h_bank = '0;
  logic [6:0] h_addr = '0;
  logic [7:0] h_wdata = '0;
  logic m_valid, m_ready = 1'b1, m_write, m_upper;
  logic [BW-1:0] m_bank;
  logic [6:0] m_addr;
  logic [7:0] m_wdata;
  logic m_rvalid = 1'b0;
  logic [7:0] m_rdata = '0;
  logic r_valid, r_ready = 1'b0;
  logic [7:0] r_data;

  int checks = 0, errors = 0, cyc = 0, mcnt = 0;
  logic [7:0] ram [0:DEPTH-1];
  logic [7:0] model [0:DEPTH-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  ram_guard_top #(.NUM_BANKS(NB)) dut (.*);

  // behavioural RAM, one-cycle read latency
  always @(posedge clk) begin
    m_rvalid <= 1'b0;
    if (m_valid && m_ready) begin
      mcnt <= mcnt + 1;
      if (m_write) ram[m_upper ? NB*128 + int'(m_addr) : int'(m_bank)*128 + int'(m_addr)] <= m_wdata;
      else begin
        m_rvalid <= 1'b1;
        m_rdata  <= ram[m_upper ? NB*128 + int'(m_addr) : int'(m_bank)*128 + int'(m_addr)];
      end
    end
  end

  // RAM back-pressure pattern
  always @(negedge clk) begin
    cyc = cyc + 1;
    m_ready = (cyc % 4) != 3;
    if (cyc > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycle %0d expected < 190000", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_block(input logic [7:0] c, input bit wr,
                                   input bit up, input int bank, input int a);
    if (up) begin
      if (c[3]) return 1;                      // R4
      if (!wr && c[4] && a < 32) return 1;     // R5
      if (wr && c[5] && a < 32) return 1;      // R6
      if (wr && c[6]) return 1;                // R7
      return 0;
    end
    if (wr && c[6] && a >= 14 && a < 64) return 1;   // R7
    if (wr && c[6] && bank == 0 && a >= 64) return 1; // R7
    if (c[7] && a >= 56 && a < 64) return 1;          // R8
    return 0;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 lock after reset", lk_rdata, 0);
    rst_n = 1'b1;
  endtask

  task automatic lock_write(input logic [7:0] v);
    @(negedge clk); lk_wr = 1'b1; lk_wdata = v;
    @(negedge clk); lk_wr = 1'b0;
  endtask

  task automatic host(input bit wr, input bit up, input int bank, input int a,
                      input logic [7:0] wd, input int rdly,
                      output logic [7:0] rd, output int mc);
    int m0;
    logic [7:0] held;
    @(negedge clk);
    while (!h_ready) @(negedge clk);
    m0 = mcnt;
    h_valid = 1'b1; h_write = wr; h_upper = up;
    h_bank = BW'(bank); h_addr = 7'(a); h_wdata = wd;
    @(negedge clk);
    h_valid = 1'b0;
    rd = 8'h00;
    if (wr) begin
      while (!h_ready) @(negedge clk);
    end else begin
      while (!r_valid) @(negedge clk);
      held = r_data;
      for (int k = 0; k < rdly; k++) begin
        @(negedge clk);
        chk("R11 response held", {r_valid, r_data}, {1'b1, held});
      end
      rd = r_data;
      r_ready = 1'b1;
      @(negedge clk);
      r_ready = 1'b0;
    end
    mc = mcnt - m0;
  endtask

  initial begin
    logic [7:0] cfgs [0:8];
    logic [7:0] rd, d, e;
    int mc;
    bit b;
    cfgs[0] = 8'h00; cfgs[1] = 8'h08; cfgs[2] = 8'h10; cfgs[3] = 8'h20;
    cfgs[4] = 8'h40; cfgs[5] = 8'h80; cfgs[6] = 8'h37; cfgs[7] = 8'hC8;
    cfgs[8] = 8'hFF;
    for (int ci = 0; ci < 9; ci++) begin
      logic [7:0] c;
      c = cfgs[ci];
      do_reset();
      lock_write(c);
      chk("R2/R3 lock readback", lk_rdata, int'(c & 8'hF8));
      for (int r = 0; r <= NB; r++) begin
        for (int a = 0; a < 128; a++) begin
          bit up;
          int idx;
          up = (r == NB);
          idx = r * 128 + a;
          d = 8'((idx * 7 + ci * 13 + 1) & 255);
          b = exp_block(c, 1, up, r, a);
          host(1, up, r, a, d, 0, rd, mc);
          chk(b ? "R12 blocked write kept off RAM" : "R10 write forwarded once", mc, b ? 0 : 1);
          if (!b) model[idx] = d;
          b = exp_block(c, 0, up, r, a);
          host(0, up, r, a, 8'h00, a % 3, rd, mc);
          e = b ? 8'hFF : model[idx];
          chk(b ? "R5/R8/R4 blocked read fill" : "R9/R10 read data", rd, e);
          chk(b ? "R12 blocked read kept off RAM" : "R10 read forwarded once", mc, b ? 0 : 1);
        end
      end
      lock_write(8'h00);
      chk("R2 zero write keeps bits", lk_rdata, int'(c & 8'hF8));
      lock_write(8'h07);
      chk("R3 reserved write ignored", lk_rdata, int'(c & 8'hF8));
      lock_write(8'h10);
      chk("R2 bits accumulate", lk_rdata, int'((c | 8'h10) & 8'hF8));
    end
    do_reset();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule